// File: doc/BRIEF.md
# Power-fail write-protect supervisor

This block sits between a host processor and an asynchronous static memory and guards the memory across supply failures. An external comparator reports whether the supply is inside tolerance. The block synchronises that signal and filters its rising edge. It then gates the host's chip-enable and write-enable strobes on their way to the memory, drives an active-low reset to the processor, and raises a flag that selects battery power for the memory.

When the supply drops, the block acts within a few clock cycles. The memory strobes are forced inactive, battery power is selected and the processor is put into reset. When the supply comes back, two independent timers start. The write lock is released first and the processor reset later, so the memory is already writable when the processor starts running. A new failure during either window blocks everything again at once and restarts both timers. A write strobe that the host is holding active when the lock lifts is not passed through until the host has been seen releasing it.

Both delays and the debounce length are parameters counted in clock cycles. The defaults suit a 100 MHz clock: 125 ms for the write lock and 350 ms for the reset.

Top module: `pfail_guard`

## Requirements
- R1: While the battery-select output is high, mem_ce_n and mem_we_n are both 1, whatever the host strobes are.
- R2: Once pwr_ok_raw goes low, mem_ce_n and mem_we_n are 1 and bat_sel is 1 no later than the third rising clock edge, and they stay so while pwr_ok_raw is low.
- R3: Once pwr_ok_raw goes low, cpu_rst_n is 0 no later than the fourth rising clock edge.
- R4: After pwr_ok_raw rises and stays high, host strobes reach the memory no sooner than WP_CYC and no later than WP_CYC+DEB_CYC+4 clock edges after the rise.
- R5: After pwr_ok_raw rises and stays high, cpu_rst_n goes to 1 no sooner than RST_CYC and no later than RST_CYC+DEB_CYC+4 edges after the rise, and never while the write lock is still in force.
- R6: bat_sel returns to 0 within DEB_CYC+3 edges of a sustained rise on pwr_ok_raw.
- R7: A high pulse on pwr_ok_raw lasting fewer than DEB_CYC cycles leaves bat_sel at 1 and the strobes blocked.
- R8: A failure during either recovery window blocks the strobes and asserts reset again, and both delays are counted again from the next rise.
- R9: If host_we_n is 0 when the write lock lifts, mem_we_n and mem_ce_n stay 1 until host_we_n has been sampled at 1 on a rising edge.
- R10: While rst_n is 0, mem_ce_n=1, mem_we_n=1, cpu_rst_n=0 and bat_sel=1, even with pwr_ok_raw high.
- R11: Once unlocked and re-armed, mem_ce_n and mem_we_n equal host_ce_n and host_we_n in the same cycle, and mem_oe_n always equals host_oe_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that counts the delays |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| pwr_ok_raw | input | 1 | Supply-good flag from the comparator, asynchronous |
| host_ce_n | input | 1 | Host chip-enable, active low |
| host_we_n | input | 1 | Host write-enable, active low |
| host_oe_n | input | 1 | Host output-enable, active low |
| mem_ce_n | output | 1 | Gated chip-enable to the memory |
| mem_we_n | output | 1 | Gated write-enable to the memory |
| mem_oe_n | output | 1 | Output-enable to the memory |
| cpu_rst_n | output | 1 | Active-low processor reset |
| bat_sel | output | 1 | High selects battery power for the memory |

## Verification
The bench builds the block with a write-lock delay of 40 cycles, a reset delay of 110 cycles, a 4-cycle debounce and two synchroniser stages. These values are small enough that full recoveries take only a few hundred cycles. That allows repeated failures placed inside both windows, glitches shorter than the debounce, and strobes held across the unlock edge. The 40-to-110 gap keeps the interval between unlock and reset release wide enough to drop the supply inside it.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

endpackage

// File: rtl/pfg_pgood_filter.sv
module pfg_pgood_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic pg_good
);
  localparam int DW = $clog2(DEB_CYC + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pg_s;
  logic [DW-1:0]          cnt_q, cnt_d;
  logic                   good_q, good_d;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= raw;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign pg_s = sync_q[SYNC_STAGES-1];

  // falling edge acts at once; rising edge needs DEB_CYC steady samples
  always_comb begin
    cnt_d  = cnt_q;
    good_d = good_q;
    if (!pg_s) begin
      cnt_d  = '0;
      good_d = 1'b0;
    end else if (!good_q) begin
      if (cnt_q == DW'(DEB_CYC - 1)) good_d = 1'b1;
      else                           cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      good_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
    end
  end

  assign pg_good = good_q;
endmodule

// File: rtl/pfg_delay_timer.sv
module pfg_delay_timer #(
  parameter int CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == CW'(CYC));
  assign cnt_en = !run || !done;

  always_comb begin
    if (!run) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pfg_strobe_gate.sv
module pfg_strobe_gate
  import pfg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    unlock,
  input  strobe_t host,
  output strobe_t mem
);
  logic armed_q, armed_d;
  logic pass;

  // re-arm only after the host write strobe is seen released
  always_comb begin
    armed_d = armed_q;
    if (!unlock)       armed_d = 1'b0;
    else if (!armed_q) armed_d = host.we_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign pass     = unlock && armed_q;
  assign mem.ce_n = host.ce_n || !pass;
  assign mem.we_n = host.we_n || !pass;
  assign mem.oe_n = host.oe_n;
endmodule

// File: rtl/pfail_guard.sv
module pfail_guard
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DEB_CYC     = 8,
  parameter int WP_CYC      = 12_500_000,
  parameter int RST_CYC     = 35_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok_raw,
  input  logic host_ce_n,
  input  logic host_we_n,
  input  logic host_oe_n,
  output logic mem_ce_n,
  output logic mem_we_n,
  output logic mem_oe_n,
  output logic cpu_rst_n,
  output logic bat_sel
);
  logic    pg_good;
  logic    wp_done;
  logic    rst_done;
  logic    unlock;
  logic    cpu_rel_q, cpu_rel_d;
  strobe_t host_s, mem_s;

  pfg_pgood_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYC(DEB_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .raw(pwr_ok_raw), .pg_good(pg_good)
  );

  pfg_delay_timer #(.CYC(WP_CYC)) u_wp_tmr (
    .clk(clk), .rst_n(rst_n), .run(pg_good), .done(wp_done)
  );

  pfg_delay_timer #(.CYC(RST_CYC)) u_rst_tmr (
    .clk(clk), .rst_n(rst_n), .run(pg_good), .done(rst_done)
  );

  assign unlock = pg_good && wp_done;

  assign host_s = '{ce_n: host_ce_n, we_n: host_we_n, oe_n: host_oe_n};

  pfg_strobe_gate u_gate (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .host(host_s), .mem(mem_s)
  );

  assign cpu_rel_d = pg_good && rst_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpu_rel_q <= 1'b0;
    else        cpu_rel_q <= cpu_rel_d;
  end

  assign mem_ce_n  = mem_s.ce_n;
  assign mem_we_n  = mem_s.we_n;
  assign mem_oe_n  = mem_s.oe_n;
  assign cpu_rst_n = cpu_rel_q;
  assign bat_sel   = !pg_good;
endmodule

// File: rtl/pfail_guard_chk.sv
module pfail_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_ok_raw,
  input logic host_we_n,
  input logic mem_ce_n,
  input logic mem_we_n,
  input logic cpu_rst_n,
  input logic bat_sel,
  input logic pg_good,
  input logic wp_done,
  input logic rst_done,
  input logic unlock
);
  logic [2:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           lo_cnt <= '0;
    else if (pwr_ok_raw)  lo_cnt <= '0;
    else if (lo_cnt != 3'd7) lo_cnt <= lo_cnt + 3'd1;
  end

  a_r1_block_on_battery: assert property (@(posedge clk) disable iff (!rst_n)
    bat_sel |-> (mem_ce_n && mem_we_n));

  a_r2_fail_blocks_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt >= 3'd3) |-> (mem_ce_n && mem_we_n && bat_sel));

  a_r3_fail_resets_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt >= 3'd4) |-> !cpu_rst_n);

  a_r5_reset_after_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_n |-> wp_done);

  a_r8_timers_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_good |=> (!wp_done && !rst_done));

  a_r9_held_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(unlock) && !host_we_n) |-> mem_we_n);
endmodule

bind pfail_guard pfail_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_ok_raw(pwr_ok_raw), .host_we_n(host_we_n),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .cpu_rst_n(cpu_rst_n),
  .bat_sel(bat_sel), .pg_good(pg_good), .wp_done(wp_done),
  .rst_done(rst_done), .unlock(unlock)
);

// File: tb/sim_pfail_guard.sv
`timescale 1ns/1ps
module sim_pfail_guard;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;
  localparam int DEB  = 4;
  localparam int WP   = 40;
  localparam int RST  = 110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok_raw = 1'b0;
  logic host_ce_n = 1'b1, host_we_n = 1'b1, host_oe_n = 1'b1;
  logic mem_ce_n, mem_we_n, mem_oe_n, cpu_rst_n, bat_sel;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfail_guard #(.SYNC_STAGES(SYNC), .DEB_CYC(DEB), .WP_CYC(WP), .RST_CYC(RST)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_ok_raw(pwr_ok_raw),
    .host_ce_n(host_ce_n), .host_we_n(host_we_n), .host_oe_n(host_oe_n),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .cpu_rst_n(cpu_rst_n), .bat_sel(bat_sel)
  );

  function automatic logic exp_gate(input logic h, input logic open);
    return h | ~open;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  // raise supply with ce=0 we=1, record edges to unlock and to reset release
  task automatic recover(output int n_unl, output int n_rst, output bit early_rst);
    n_unl = -1; n_rst = -1; early_rst = 0;
    host_ce_n = 1'b0; host_we_n = 1'b1;
    pwr_ok_raw = 1'b1;
    for (int n = 1; n <= RST + DEB + 20; n++) begin
      tick();
      if (n_unl < 0 && mem_ce_n == 1'b0) n_unl = n;
      if (n_rst < 0 && cpu_rst_n == 1'b1) begin
        n_rst = n;
        if (n_unl < 0) early_rst = 1;
      end
      if (n_unl >= 0 && n_rst >= 0) break;
    end
  endtask

  task automatic fail_and_check(input string tag);
    int nb, nr;
    nb = -1; nr = -1;
    host_ce_n = 1'b0; host_we_n = 1'b1;
    pwr_ok_raw = 1'b0;
    for (int n = 1; n <= 8; n++) begin
      tick();
      if (nb < 0 && mem_ce_n && mem_we_n && bat_sel) nb = n;
      if (nr < 0 && !cpu_rst_n) nr = n;
    end
    chk(nb > 0 && nb <= 3, {tag, " R2 block latency"}, nb, 3);
    chk(nr > 0 && nr <= 4, {tag, " R3 reset latency"}, nr, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nu, nr, seed;
    bit er;
    logic okv;
    seed = 32'h5eed_0a17;
    void'($urandom(seed));

    // R10: reset state with supply reported good
    pwr_ok_raw = 1'b1; host_ce_n = 1'b0; host_we_n = 1'b0; host_oe_n = 1'b0;
    repeat (5) tick();
    chk(mem_ce_n == 1'b1, "R10 mem_ce_n in reset", mem_ce_n, 1);
    chk(mem_we_n == 1'b1, "R10 mem_we_n in reset", mem_we_n, 1);
    chk(cpu_rst_n == 1'b0, "R10 cpu_rst_n in reset", cpu_rst_n, 0);
    chk(bat_sel == 1'b1, "R10 bat_sel in reset", bat_sel, 1);
    chk(mem_oe_n == host_oe_n, "R11 oe pass in reset", mem_oe_n, host_oe_n);
    pwr_ok_raw = 1'b0; host_we_n = 1'b1;
    rst_n = 1'b1;
    repeat (6) tick();
    chk(bat_sel == 1'b1, "R1 bat_sel while down", bat_sel, 1);

    // R7: short glitch
    pwr_ok_raw = 1'b1; tick(); tick(); pwr_ok_raw = 1'b0;
    okv = 1'b1;
    for (int n = 0; n < 12; n++) begin
      tick();
      if (!bat_sel || !mem_ce_n) okv = 1'b0;
    end
    chk(okv, "R7 glitch ignored", okv, 1);

    // R4/R5/R6: first full recovery, bat_sel latency
    host_ce_n = 1'b0; host_we_n = 1'b1; pwr_ok_raw = 1'b1;
    nu = -1;
    for (int n = 1; n <= DEB + 6; n++) begin
      tick();
      if (nu < 0 && !bat_sel) nu = n;
    end
    chk(nu > 0 && nu <= DEB + 3, "R6 bat_sel release", nu, DEB + 3);
    pwr_ok_raw = 1'b0; repeat (6) tick();
    recover(nu, nr, er);
    chk(nu >= WP && nu <= WP + DEB + 4, "R4 unlock delay", nu, WP);
    chk(nr >= RST && nr <= RST + DEB + 4, "R5 reset delay", nr, RST);
    chk(!er, "R5 reset before unlock", er, 0);

    // R11: random strobes while up
    for (int n = 0; n < 300; n++) begin
      host_ce_n = 1'($urandom); host_we_n = 1'($urandom); host_oe_n = 1'($urandom);
      #1;
      chk(mem_ce_n == exp_gate(host_ce_n, 1'b1) && mem_we_n == exp_gate(host_we_n, 1'b1)
          && mem_oe_n == host_oe_n, "R11 pass-through", {mem_ce_n, mem_we_n, mem_oe_n},
          {host_ce_n, host_we_n, host_oe_n});
      tick();
    end

    // random fail/recover episodes, strobes random while down
    for (int ep = 0; ep < 5; ep++) begin
      fail_and_check("episode");
      for (int n = 0; n < 5 + int'($urandom_range(25)); n++) begin
        host_ce_n = 1'($urandom); host_we_n = 1'($urandom); host_oe_n = 1'($urandom);
        #1;
        chk(mem_ce_n == exp_gate(host_ce_n, 1'b0) && mem_we_n == exp_gate(host_we_n, 1'b0),
            "R1 blocked while down", {mem_ce_n, mem_we_n}, 3);
        chk(mem_oe_n == host_oe_n, "R11 oe while down", mem_oe_n, host_oe_n);
        tick();
      end
      recover(nu, nr, er);
      chk(nu >= WP && nu <= WP + DEB + 4, "R4 unlock delay episode", nu, WP);
      chk(nr >= RST && nr <= RST + DEB + 4, "R5 reset delay episode", nr, RST);
    end

    // R8: failure inside the write-lock window
    fail_and_check("R8 lock window");
    pwr_ok_raw = 1'b1; repeat (WP / 2) tick();
    pwr_ok_raw = 1'b0; repeat (6) tick();
    chk(mem_ce_n && bat_sel && !cpu_rst_n, "R8 re-blocked in lock window",
        {mem_ce_n, bat_sel, cpu_rst_n}, 6);
    recover(nu, nr, er);
    chk(nu >= WP && nu <= WP + DEB + 4, "R8 unlock recounted", nu, WP);

    // R8: failure between unlock and reset release
    fail_and_check("R8 reset window");
    pwr_ok_raw = 1'b1; host_ce_n = 1'b0; host_we_n = 1'b1;
    repeat (WP + DEB + 10) tick();
    chk(mem_ce_n == 1'b0 && cpu_rst_n == 1'b0, "R8 unlocked, still in reset",
        {mem_ce_n, cpu_rst_n}, 0);
    fail_and_check("R8 reset window drop");
    recover(nu, nr, er);
    chk(nr >= RST && nr <= RST + DEB + 4, "R8 reset recounted", nr, RST);

    // R9: write held across unlock
    fail_and_check("R9 setup");
    host_ce_n = 1'b0; host_we_n = 1'b0; pwr_ok_raw = 1'b1;
    repeat (WP + DEB + 10) tick();
    chk(mem_we_n == 1'b1 && mem_ce_n == 1'b1, "R9 held write blocked",
        {mem_ce_n, mem_we_n}, 3);
    host_we_n = 1'b1; tick();
    chk(mem_ce_n == 1'b0, "R9 re-armed after release", mem_ce_n, 0);
    host_we_n = 1'b0; #1;
    chk(mem_we_n == 1'b0, "R9 write passes after re-arm", mem_we_n, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule